// File: doc/BRIEF.md
# Debug Event Redirection Unit

This unit sits between a small processor's decode and exception logic and its debug-port interface. It collects five kinds of debug event and turns each into exactly one of two outgoing requests.

The five events are:
- a fetched one-byte breakpoint opcode;
- a software vector-1 interrupt;
- a trap-flag single step;
- a breakpoint exception;
- a task switch into a task whose trap bit is set.

A single redirection bit picks the destination of every event. With the bit clear, an event becomes an ordinary handler request on vector 1, or on vector 3 for the breakpoint exception. With the bit set, the event becomes a break request to an external emulator.

If the redirection bit is set and no emulator is attached, the unit freezes instead. It withdraws instruction retirement and stays frozen until reset.

Events are held as pending flags and granted one at a time in a fixed priority order. Each granted request stays asserted until the consumer acknowledges it.

The flag image that accompanies a handler request is captured as is. The breakpoint opcode therefore leaves the trap flag in the saved image exactly as it was, and returning from the handler does not re-trigger stepping.

A build parameter chooses who may write the redirection bit:
- `WR_MODE=0`: software writes it.
- `WR_MODE=1`: only the debug port writes it, and it may do so while the core runs.

In both modes, arming a hardware address breakpoint from the debug port sets the bit.

Top module: `dbg_redirect_unit`

## Requirements
- R1: A byte equal to 0xF1, presented with `fetch_valid` and `fetch_first` high, registers a breakpoint-opcode event. With redirection clear, this gives `vec_req`=1, `vec_num`=1 and `event_id`=1 two clock edges after the byte is presented.
- R2: On every grant, `saved_flags` takes the value of `flags_in` from the grant cycle. The trap flag (bit 8) is neither set nor cleared, whether it was 0 or 1.
- R3: With redirection set and `emu_present` high, a granted event raises `emu_break_req` and not `vec_req`, and `vec_num` reads 0. The two request outputs are never high together.
- R4: With redirection set and `emu_present` low, a granted event sets `hang`=1 and `retire_en`=0. No request is raised. Only reset leaves this state: later events and writes have no effect on it.
- R5: While redirection is set, all five event kinds are redirected to the emulator break request.
- R6: With redirection clear, the event kinds map to `event_id` and `vec_num` as follows:

  | Event | `event_id` | `vec_num` |
  |---|---|---|
  | software vector-1 interrupt | 2 | 1 |
  | single step | 3 | 1 |
  | breakpoint exception | 4 | 3 |
  | task-switch trap | 5 | 1 |

  `event_id`=0 means no request.
- R7: One event is granted at a time, in the priority order task-switch trap > breakpoint exception > single step > software vector-1 interrupt > breakpoint opcode. Events that are not granted remain pending. The next one is granted two edges after `req_ack` is pulsed.
- R8: A granted request and its `event_id` hold steady until `req_ack`.
- R9: With `WR_MODE=0`, a pulse on `sw_wr_en` loads `sw_wr_data` into `redir_bit` at the next edge, and `dp_wr_en` has no effect.
- R10: With `WR_MODE=1`, a pulse on `dp_wr_en` loads `dp_wr_data` into `redir_bit`, including while a request is outstanding, and `sw_wr_en` has no effect.
- R11: A pulse on `dp_hwbp_arm` sets `redir_bit` in both modes, overriding a simultaneous write of 0.
- R12: After reset: `redir_bit`=0, `hang`=0, `retire_en`=1, no request, `event_id`=0.
- R13: A 0xF1 byte with `fetch_first` low, or any other byte, raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetched byte is valid |
| fetch_first | input | 1 | Byte is the first byte of an instruction |
| fetch_byte | input | 8 | Fetched byte |
| ev_int01 | input | 1 | Software vector-1 interrupt pulse |
| ev_step | input | 1 | Trap-flag single-step pulse |
| ev_bpx | input | 1 | Breakpoint exception pulse |
| ev_task | input | 1 | Task switch into a trapping task pulse |
| flags_in | input | 16 | Current flag word |
| sw_wr_en | input | 1 | Software write strobe for the redirection bit |
| sw_wr_data | input | 1 | Software write value |
| dp_wr_en | input | 1 | Debug-port write strobe for the redirection bit |
| dp_wr_data | input | 1 | Debug-port write value |
| dp_hwbp_arm | input | 1 | Debug port arms a hardware address breakpoint |
| emu_present | input | 1 | External emulator attached |
| req_ack | input | 1 | Acknowledge of the outstanding request |
| vec_req | output | 1 | Handler request |
| vec_num | output | 8 | Handler vector number |
| emu_break_req | output | 1 | Emulator break request |
| event_id | output | 3 | Code of the granted event |
| saved_flags | output | 16 | Flag image captured at grant |
| hang | output | 1 | Frozen state |
| retire_en | output | 1 | Instruction retirement allowed |
| redir_bit | output | 1 | Read-back of the redirection bit |

## Verification
The bench builds two copies side by side, `WR_MODE=0` and `WR_MODE=1`, both with the default opcode 0xF1. The two copies share every input, so a single write strobe shows one copy loading the bit while the other ignores it. It also lets a debug-port write to the second copy land while that copy has a request outstanding. The priority drain, the frozen state and the pass-through of the trap flag are exercised on the software-write copy.

// File: rtl/dbgr_pkg.sv
package dbgr_pkg;
  localparam int NUM_EV = 5;
  localparam int ID_W   = 3;
  typedef enum logic [ID_W-1:0] {
    EV_NONE   = 3'd0,
    EV_OPCODE = 3'd1,
    EV_INT01  = 3'd2,
    EV_STEP   = 3'd3,
    EV_BPX    = 3'd4,
    EV_TASK   = 3'd5
  } dbg_ev_e;
  localparam logic [7:0] VEC_STEP = 8'd1;
  localparam logic [7:0] VEC_BP   = 8'd3;
  localparam int BPX_IDX = 3;
endpackage

// File: rtl/dbgr_opcode_detect.sv
module dbgr_opcode_detect #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPC = 8'hF1
) (
  input  logic              fetch_valid,
  input  logic              fetch_first,
  input  logic [BYTE_W-1:0] fetch_byte,
  output logic              hit
);
  assign hit = fetch_valid & fetch_first & (fetch_byte == OPC);
endmodule

// File: rtl/dbgr_redir_reg.sv
module dbgr_redir_reg #(
  parameter int WR_MODE = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr_en,
  input  logic sw_wr_data,
  input  logic dp_wr_en,
  input  logic dp_wr_data,
  input  logic dp_hwbp_arm,
  output logic redir
);
  logic sel_en, sel_data, redir_n, upd;

  generate
    if (WR_MODE == 0) begin : g_sw_path
      assign sel_en   = sw_wr_en;
      assign sel_data = sw_wr_data;
    end else begin : g_dp_path
      assign sel_en   = dp_wr_en;
      assign sel_data = dp_wr_data;
    end
  endgenerate

  always_comb begin
    redir_n = redir;
    if (sel_en)      redir_n = sel_data;
    if (dp_hwbp_arm) redir_n = 1'b1;
  end

  assign upd = sel_en | dp_hwbp_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   redir <= 1'b0;
    else if (upd) redir <= redir_n;
  end
endmodule

// File: rtl/dbgr_arbiter.sv
module dbgr_arbiter
  import dbgr_pkg::*;
#(
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic              redir,
  input  logic              emu_present,
  input  logic              req_ack,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              vec_req,
  output logic              emu_break_req,
  output logic [7:0]        vec_num,
  output logic [ID_W-1:0]   event_id,
  output logic [FLAG_W-1:0] saved_flags,
  output logic              hang
);
  logic [NUM_EV-1:0] pend, pend_n, clr;
  logic [ID_W-1:0]   sel_idx, id_n;
  logic              sel_any, busy;
  logic              vreq_n, ereq_n, hang_n;
  logic [7:0]        num_n;
  logic [FLAG_W-1:0] flg_n;

  assign busy = vec_req | emu_break_req;

  // highest index wins: task > bpx > step > int01 > opcode
  always_comb begin
    sel_idx = '0;
    sel_any = 1'b0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (pend[i]) begin
        sel_idx = ID_W'(i);
        sel_any = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_EV; i++)
      clr[i] = busy & req_ack & (event_id == ID_W'(i + 1));
  end

  always_comb begin
    pend_n = (pend & ~clr) | ev_in;
    vreq_n = vec_req;
    ereq_n = emu_break_req;
    id_n   = event_id;
    num_n  = vec_num;
    flg_n  = saved_flags;
    hang_n = hang;
    if (hang) begin
      pend_n = pend;
    end else if (busy) begin
      if (req_ack) begin
        vreq_n = 1'b0;
        ereq_n = 1'b0;
        id_n   = EV_NONE;
        num_n  = '0;
      end
    end else if (sel_any) begin
      if (redir && !emu_present) begin
        hang_n = 1'b1;
      end else begin
        vreq_n = ~redir;
        ereq_n = redir;
        id_n   = sel_idx + ID_W'(1);
        num_n  = redir ? 8'd0 : ((sel_idx == ID_W'(BPX_IDX)) ? VEC_BP : VEC_STEP);
        flg_n  = flags_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend          <= '0;
      vec_req       <= 1'b0;
      emu_break_req <= 1'b0;
      event_id      <= EV_NONE;
      vec_num       <= '0;
      saved_flags   <= '0;
      hang          <= 1'b0;
    end else begin
      pend          <= pend_n;
      vec_req       <= vreq_n;
      emu_break_req <= ereq_n;
      event_id      <= id_n;
      vec_num       <= num_n;
      saved_flags   <= flg_n;
      hang          <= hang_n;
    end
  end
endmodule

// File: rtl/dbg_redirect_unit.sv
module dbg_redirect_unit
  import dbgr_pkg::*;
#(
  parameter int WR_MODE = 0,
  parameter int FLAG_W  = 16,
  parameter int BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] OPC = 8'hF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              fetch_first,
  input  logic [BYTE_W-1:0] fetch_byte,
  input  logic              ev_int01,
  input  logic              ev_step,
  input  logic              ev_bpx,
  input  logic              ev_task,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              sw_wr_en,
  input  logic              sw_wr_data,
  input  logic              dp_wr_en,
  input  logic              dp_wr_data,
  input  logic              dp_hwbp_arm,
  input  logic              emu_present,
  input  logic              req_ack,
  output logic              vec_req,
  output logic [7:0]        vec_num,
  output logic              emu_break_req,
  output logic [ID_W-1:0]   event_id,
  output logic [FLAG_W-1:0] saved_flags,
  output logic              hang,
  output logic              retire_en,
  output logic              redir_bit
);
  logic rst_q1, rst_n_s;
  logic opc_hit;
  logic [NUM_EV-1:0] ev_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_q1  <= 1'b1;
      rst_n_s <= rst_q1;
    end
  end

  dbgr_opcode_detect #(.BYTE_W(BYTE_W), .OPC(OPC)) u_opc (
    .fetch_valid(fetch_valid), .fetch_first(fetch_first),
    .fetch_byte(fetch_byte), .hit(opc_hit)
  );

  assign ev_vec = {ev_task, ev_bpx, ev_step, ev_int01, opc_hit};

  dbgr_redir_reg #(.WR_MODE(WR_MODE)) u_reg (
    .clk(clk), .rst_n(rst_n_s),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .dp_wr_en(dp_wr_en), .dp_wr_data(dp_wr_data),
    .dp_hwbp_arm(dp_hwbp_arm), .redir(redir_bit)
  );

  dbgr_arbiter #(.FLAG_W(FLAG_W)) u_arb (
    .clk(clk), .rst_n(rst_n_s), .ev_in(ev_vec),
    .redir(redir_bit), .emu_present(emu_present), .req_ack(req_ack),
    .flags_in(flags_in), .vec_req(vec_req), .emu_break_req(emu_break_req),
    .vec_num(vec_num), .event_id(event_id), .saved_flags(saved_flags),
    .hang(hang)
  );

  assign retire_en = ~hang;
endmodule

// File: rtl/dbgr_checker.sv
module dbgr_checker #(
  parameter int WR_MODE = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_wr_en,
  input logic       sw_wr_data,
  input logic       dp_wr_en,
  input logic       dp_wr_data,
  input logic       dp_hwbp_arm,
  input logic       req_ack,
  input logic       vec_req,
  input logic       emu_break_req,
  input logic [2:0] event_id,
  input logic [7:0] vec_num,
  input logic       hang,
  input logic       retire_en,
  input logic       redir_bit
);
  p_req_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_req && emu_break_req));

  p_hang_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hang |=> hang);

  p_hang_no_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hang |-> (!retire_en && !vec_req && !emu_break_req));

  p_bpx_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && event_id == 3'd4) |-> (vec_num == 8'd3));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_req || emu_break_req) && !req_ack) |=>
      ((vec_req || emu_break_req) && $stable(event_id)));

  p_sw_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (WR_MODE == 1 && sw_wr_en && !dp_wr_en && !dp_hwbp_arm) |=> $stable(redir_bit));

  p_dp_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (WR_MODE == 0 && dp_wr_en && !sw_wr_en && !dp_hwbp_arm) |=> $stable(redir_bit));

  p_arm_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dp_hwbp_arm |=> redir_bit);
endmodule

bind dbg_redirect_unit dbgr_checker #(.WR_MODE(WR_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n_s),
  .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
  .dp_wr_en(dp_wr_en), .dp_wr_data(dp_wr_data),
  .dp_hwbp_arm(dp_hwbp_arm), .req_ack(req_ack),
  .vec_req(vec_req), .emu_break_req(emu_break_req),
  .event_id(event_id), .vec_num(vec_num),
  .hang(hang), .retire_en(retire_en), .redir_bit(redir_bit)
);

// File: tb/dbg_redirect_unit_tb.sv
module dbg_redirect_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 0, fetch_first = 0;
  logic [7:0] fetch_byte = 8'h00;
  logic ev_int01 = 0, ev_step = 0, ev_bpx = 0, ev_task = 0;
  logic [15:0] flags_in = 16'h0002;
  logic sw_wr_en = 0, sw_wr_data = 0, dp_wr_en = 0, dp_wr_data = 0, dp_hwbp_arm = 0;
  logic emu_present = 1'b1, req_ack = 1'b0;

  logic vec_req, emu_req, hang, retire_en, redir_bit;
  logic [7:0] vec_num;
  logic [2:0] event_id;
  logic [15:0] saved_flags;
  logic d_vec_req, d_emu_req, d_hang, d_retire, d_redir;
  logic [7:0] d_vec_num;
  logic [2:0] d_event_id;
  logic [15:0] d_saved_flags;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_redirect_unit #(.WR_MODE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_first(fetch_first),
    .fetch_byte(fetch_byte), .ev_int01(ev_int01), .ev_step(ev_step), .ev_bpx(ev_bpx),
    .ev_task(ev_task), .flags_in(flags_in), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .dp_wr_en(dp_wr_en), .dp_wr_data(dp_wr_data), .dp_hwbp_arm(dp_hwbp_arm),
    .emu_present(emu_present), .req_ack(req_ack), .vec_req(vec_req), .vec_num(vec_num),
    .emu_break_req(emu_req), .event_id(event_id), .saved_flags(saved_flags),
    .hang(hang), .retire_en(retire_en), .redir_bit(redir_bit)
  );

  dbg_redirect_unit #(.WR_MODE(1)) u_dut_dp (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_first(fetch_first),
    .fetch_byte(fetch_byte), .ev_int01(ev_int01), .ev_step(ev_step), .ev_bpx(ev_bpx),
    .ev_task(ev_task), .flags_in(flags_in), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .dp_wr_en(dp_wr_en), .dp_wr_data(dp_wr_data), .dp_hwbp_arm(dp_hwbp_arm),
    .emu_present(emu_present), .req_ack(req_ack), .vec_req(d_vec_req), .vec_num(d_vec_num),
    .emu_break_req(d_emu_req), .event_id(d_event_id), .saved_flags(d_saved_flags),
    .hang(d_hang), .retire_en(d_retire), .redir_bit(d_redir)
  );

  typedef struct packed {
    logic [4:0] ev;    // {task, bpx, step, int01, opcode}
    logic       redir;
    logic       emu;
    logic       evec;
    logic       eemu;
    logic [7:0] enum_v;
    logic [2:0] eid;
    logic       ehang;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{5'b00001, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 3'd1, 1'b0},
    '{5'b00010, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 3'd2, 1'b0},
    '{5'b00100, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 3'd3, 1'b0},
    '{5'b01000, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3, 3'd4, 1'b0},
    '{5'b10000, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 3'd5, 1'b0},
    '{5'b00001, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 3'd1, 1'b0},
    '{5'b00010, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 3'd2, 1'b0},
    '{5'b00100, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 3'd3, 1'b0},
    '{5'b01000, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 3'd4, 1'b0},
    '{5'b10000, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 3'd5, 1'b0},
    '{5'b00100, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 3'd0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // starts and ends at a negedge; outputs of the grant are visible on return
  task automatic pulse(input logic [4:0] m);
    fetch_valid = m[0]; fetch_first = m[0]; fetch_byte = m[0] ? 8'hF1 : 8'h00;
    ev_int01 = m[1]; ev_step = m[2]; ev_bpx = m[3]; ev_task = m[4];
    @(negedge clk);
    fetch_valid = 0; fetch_first = 0; fetch_byte = 8'h00;
    ev_int01 = 0; ev_step = 0; ev_bpx = 0; ev_task = 0;
    @(negedge clk);
  endtask

  task automatic ack();
    req_ack = 1'b1;
    @(negedge clk);
    req_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_write(input logic v);
    sw_wr_en = 1'b1; sw_wr_data = v;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  task automatic dp_write(input logic v);
    dp_wr_en = 1'b1; dp_wr_data = v;
    @(negedge clk);
    dp_wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 redir_bit", redir_bit, 0);
    chk("R12 hang", hang, 0);
    chk("R12 retire_en", retire_en, 1);
    chk("R12 vec_req", vec_req, 0);
    chk("R12 emu_break_req", emu_req, 0);
    chk("R12 event_id", event_id, 0);

    // table walk: R1 R3 R5 R6 R4
    for (int k = 0; k < NV; k++) begin
      if (redir_bit !== TBL[k].redir) sw_write(TBL[k].redir);
      emu_present = TBL[k].emu;
      pulse(TBL[k].ev);
      chk($sformatf("R5/R6 vec_req v%0d", k), vec_req, TBL[k].evec);
      chk($sformatf("R3/R5 emu_break_req v%0d", k), emu_req, TBL[k].eemu);
      chk($sformatf("R1/R6 vec_num v%0d", k), vec_num, TBL[k].enum_v);
      chk($sformatf("R6 event_id v%0d", k), event_id, TBL[k].eid);
      chk($sformatf("R4 hang v%0d", k), hang, TBL[k].ehang);
      chk($sformatf("R4 retire_en v%0d", k), retire_en, !TBL[k].ehang);
      if (TBL[k].ehang) begin
        // R4 sticky: further events and writes leave it frozen
        repeat (3) @(negedge clk);
        pulse(5'b00010);
        sw_write(1'b0);
        emu_present = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 hang sticky", hang, 1);
        chk("R4 no request in hang", vec_req | emu_req, 0);
        chk("R4 retire held off", retire_en, 0);
        emu_present = 1'b1;
        do_reset();
        chk("R4 reset leaves hang", hang, 0);
      end else begin
        ack();
      end
    end

    // R13 ignored bytes
    do_reset();
    fetch_valid = 1; fetch_first = 0; fetch_byte = 8'hF1;
    @(negedge clk);
    fetch_first = 1; fetch_byte = 8'hF0;
    @(negedge clk);
    fetch_valid = 0; fetch_first = 0; fetch_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R13 no request", vec_req | emu_req, 0);
    chk("R13 event_id", event_id, 0);

    // R2 trap flag pass-through
    flags_in = 16'h0103;
    pulse(5'b00001);
    chk("R2 saved_flags tf=1", saved_flags, 16'h0103);
    ack();
    flags_in = 16'h00C6;
    pulse(5'b00001);
    chk("R2 saved_flags tf=0", saved_flags, 16'h00C6);
    ack();

    // R7 priority drain
    pulse(5'b11111);
    chk("R7 first id", event_id, 5);
    chk("R7 first vec", vec_num, 1);
    ack();
    chk("R7 second id", event_id, 4);
    chk("R7 second vec", vec_num, 3);
    ack();
    chk("R7 third id", event_id, 3);
    ack();
    chk("R7 fourth id", event_id, 2);
    ack();
    chk("R7 fifth id", event_id, 1);
    ack();
    chk("R7 drained", vec_req, 0);
    chk("R7 drained id", event_id, 0);

    // R8 hold without ack
    pulse(5'b00010);
    repeat (3) @(negedge clk);
    chk("R8 held vec_req", vec_req, 1);
    chk("R8 held id", event_id, 2);
    ack();

    // R9 / R10 write paths
    do_reset();
    dp_write(1'b1);
    chk("R9 dp write ignored in sw mode", redir_bit, 0);
    chk("R10 dp write loads in dp mode", d_redir, 1);
    sw_write(1'b1);
    chk("R9 sw write loads", redir_bit, 1);
    sw_write(1'b0);
    chk("R9 sw write clears", redir_bit, 0);
    chk("R10 sw write ignored in dp mode", d_redir, 1);
    dp_write(1'b0);
    chk("R10 dp write clears", d_redir, 0);
    // R10 change while a request is outstanding
    pulse(5'b00010);
    dp_write(1'b1);
    chk("R10 running write", d_redir, 1);
    chk("R10 request still up", d_vec_req, 1);
    ack();
    pulse(5'b00100);
    chk("R10 dp copy redirects", d_emu_req, 1);
    chk("R10 sw copy to handler", vec_req, 1);
    ack();

    // R11 arm overrides clear
    do_reset();
    dp_hwbp_arm = 1'b1; sw_wr_en = 1'b1; sw_wr_data = 1'b0; dp_wr_en = 1'b1; dp_wr_data = 1'b0;
    @(negedge clk);
    dp_hwbp_arm = 1'b0; sw_wr_en = 1'b0; dp_wr_en = 1'b0;
    chk("R11 arm sets sw copy", redir_bit, 1);
    chk("R11 arm sets dp copy", d_redir, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule